// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar date as packed BCD values. The chain runs from hundredths of a second through seconds, minutes, hours, day of month, month and a two-digit year. A day-of-week counter and a three-digit day-of-year counter sit beside it. A single enable input, `tick_en`, comes from the oscillator. An internal prescaler divides it down so that the hundredths digit advances once every `PRESCALE_DIV` enabled ticks. Each carry ripples up the chain within the same clock edge.

Hours are always held internally in 24-hour form. Software picks a 12-hour or a 24-hour view through a mode bit. In 12-hour view the hour output reads 12, 1 … 11, and a PM flag marks the afternoon half of the day. February is given 29 days when the year is divisible by four.

Software loads any counter through a one-cycle write port with a 4-bit selector. Every counter is always visible on the read outputs.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the time is 00:00:00.00, day of month 01, month 01, year 00, day of week 1, day of year 001, and 24-hour mode is selected.
- R2: The hundredths counter advances by one after every `PRESCALE_DIV` cycles with `tick_en` high and no write. Without `tick_en` no counter changes.
- R3: Hundredths wraps from 99 to 00 and carries into seconds. Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours.
- R4: Internally hours run from 00 to 23. A wrap from 23 to 00 produces a day carry. In 24-hour mode `hour_o` shows this value.
- R5: When `mode12_o`=1, `hour_o` shows 12, 01 … 11 in BCD. `pm_o` is 1 for internal hours 12 to 23 and 0 otherwise, so it rises when the display steps from 11 to 12. Changing the mode leaves the time untouched.
- R6: A write to the hour (selector 3) in 12-hour mode takes `wr_data[7:0]` as an hour from 01 to 12 and `wr_data[8]` as PM. In 24-hour mode `wr_data[7:0]` is loaded as is.
- R7: On a day carry, day of month returns to 01 after the month's last day: 30 for months 04, 06, 09 and 11, 28 or 29 for month 02, and 31 otherwise. The month then advances. Month 12 returns to 01 and advances the year, and year 99 returns to 00.
- R8: February has 29 days when the BCD year is divisible by four, including year 00, and 28 days otherwise.
- R9: On each day carry, day of week steps through 1 to 7 and returns to 1.
- R10: On each day carry, day of year counts up in three BCD digits. It returns to 001 when the month wraps from 12 to 01, or after 365 (366 in a leap year).
- R11: A write is applied at the next clock edge and clears the prescaler, and no counting happens in that cycle. The selectors are: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day of month, 5 month, 6 year, 7 day of week (`wr_data[3:0]`), 8 day of year (`wr_data[11:0]`), and 9 mode (`wr_data[0]`, 1 = 12-hour). A write to any selector other than 3 loads `wr_data[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Oscillator-derived count enable |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_sel | input | 4 | Counter selector |
| wr_data | input | 12 | Write value |
| hund_o | output | 8 | Hundredths, BCD |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hour in the selected view, BCD |
| pm_o | output | 1 | Afternoon flag |
| mode12_o | output | 1 | 12-hour view selected |
| dom_o | output | 8 | Day of month, BCD |
| mon_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year, BCD |
| dow_o | output | 4 | Day of week, 1 to 7 |
| doy_o | output | 12 | Day of year, BCD |

## Verification
The bench builds the block with `PRESCALE_DIV` = 2. At that value a hundredth advances every second enabled tick, so the prescaler's terminal count and its clearing by a write both occur many times over a short run. Directed loads of 23:59:59.99 on month-end dates then push single steps through every month length and leap case, the year wrap and the AM/PM change, all within a few cycles. Random ticks and random valid writes fill in the remaining mix of loads and steps.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef enum logic [3:0] {
    SEL_HUND = 4'd0, SEL_SEC = 4'd1, SEL_MIN = 4'd2, SEL_HOUR = 4'd3,
    SEL_DOM  = 4'd4, SEL_MON = 4'd5, SEL_YEAR = 4'd6, SEL_DOW = 4'd7,
    SEL_DOY  = 4'd8, SEL_MODE = 4'd9
  } cal_sel_e;

  function automatic logic [6:0] bcd_to_bin(logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic [7:0] bin_to_bcd(logic [6:0] b);
    return {4'(b / 7'd10), 4'(b % 7'd10)};
  endfunction

  function automatic logic [7:0] bcd_inc2(logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [11:0] bcd_inc3(logic [11:0] v);
    if (v[7:0] == 8'h99) return {v[11:8] + 4'd1, 8'h00};
    return {v[11:8], bcd_inc2(v[7:0])};
  endfunction

  // Divisible by four: tens digit parity selects the allowed units digits.
  function automatic logic is_leap(logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_days(logic [7:0] m, logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] hour_to_12(logic [7:0] h24);
    logic [6:0] b;
    b = bcd_to_bin(h24) % 7'd12;
    return (b == 7'd0) ? 8'h12 : bin_to_bcd(b);
  endfunction

  function automatic logic [7:0] hour_from_12(logic [7:0] h12, logic pm);
    logic [6:0] b;
    b = bcd_to_bin(h12) % 7'd12;
    return bin_to_bcd(pm ? b + 7'd12 : b);
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int PRESCALE_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic clear,
  output logic step
);
  localparam int CW = (PRESCALE_DIV > 1) ? $clog2(PRESCALE_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESCALE_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign step    = tick_en && !clear && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clear)             cnt_q <= '0;
    else if (tick_en && at_last) cnt_q <= '0;
    else if (tick_en)           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cal_time_chain.sv
module cal_time_chain
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       mode12,
  input  logic       wr_en,
  input  logic [3:0] wr_sel,
  input  logic [8:0] wr_data,
  output logic [7:0] hund,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hour24,
  output logic       hund_wrap,
  output logic       sec_wrap,
  output logic       min_wrap,
  output logic       day_step
);
  assign hund_wrap = step && (hund == 8'h99);
  assign sec_wrap  = hund_wrap && (sec == 8'h59);
  assign min_wrap  = sec_wrap && (min == 8'h59);
  assign day_step  = min_wrap && (hour24 == 8'h23);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hund <= 8'h00; sec <= 8'h00; min <= 8'h00; hour24 <= 8'h00;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_HUND: hund <= wr_data[7:0];
        SEL_SEC:  sec  <= wr_data[7:0];
        SEL_MIN:  min  <= wr_data[7:0];
        SEL_HOUR: hour24 <= mode12 ? hour_from_12(wr_data[7:0], wr_data[8])
                                   : wr_data[7:0];
        default: ;
      endcase
    end else if (step) begin
      hund <= hund_wrap ? 8'h00 : bcd_inc2(hund);
      if (hund_wrap) sec    <= sec_wrap ? 8'h00 : bcd_inc2(sec);
      if (sec_wrap)  min    <= min_wrap ? 8'h00 : bcd_inc2(min);
      if (min_wrap)  hour24 <= day_step ? 8'h00 : bcd_inc2(hour24);
    end
  end
endmodule

// File: rtl/cal_date_chain.sv
module cal_date_chain
  import cal_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        day_step,
  input  logic        wr_en,
  input  logic [3:0]  wr_sel,
  input  logic [11:0] wr_data,
  output logic [7:0]  dom,
  output logic [7:0]  mon,
  output logic [7:0]  year,
  output logic [3:0]  dow,
  output logic [11:0] doy,
  output logic        leap,
  output logic        new_year
);
  logic       month_end;
  logic [7:0] mlen;

  assign leap      = is_leap(year);
  assign mlen      = month_days(mon, leap);
  assign month_end = day_step && (dom == mlen);
  assign new_year  = month_end && (mon == 8'h12);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dom <= 8'h01; mon <= 8'h01; year <= 8'h00; dow <= 4'd1; doy <= 12'h001;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_DOM:  dom  <= wr_data[7:0];
        SEL_MON:  mon  <= wr_data[7:0];
        SEL_YEAR: year <= wr_data[7:0];
        SEL_DOW:  dow  <= wr_data[3:0];
        SEL_DOY:  doy  <= wr_data;
        default: ;
      endcase
    end else if (day_step) begin
      dom <= month_end ? 8'h01 : bcd_inc2(dom);
      dow <= (dow == 4'd7) ? 4'd1 : dow + 4'd1;
      if (new_year || doy == (leap ? 12'h366 : 12'h365)) doy <= 12'h001;
      else                                                doy <= bcd_inc3(doy);
      if (month_end) mon  <= new_year ? 8'h01 : bcd_inc2(mon);
      if (new_year)  year <= (year == 8'h99) ? 8'h00 : bcd_inc2(year);
    end
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int PRESCALE_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        wr_en,
  input  logic [3:0]  wr_sel,
  input  logic [11:0] wr_data,
  output logic [7:0]  hund_o,
  output logic [7:0]  sec_o,
  output logic [7:0]  min_o,
  output logic [7:0]  hour_o,
  output logic        pm_o,
  output logic        mode12_o,
  output logic [7:0]  dom_o,
  output logic [7:0]  mon_o,
  output logic [7:0]  year_o,
  output logic [3:0]  dow_o,
  output logic [11:0] doy_o
);
  // Named internal events, also observed by the bound checker.
  logic       step, hund_wrap, sec_wrap, min_wrap, day_step, new_year, leap;
  logic [7:0] hour24;
  logic       mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                mode_q <= 1'b0;
    else if (wr_en && wr_sel == SEL_MODE)      mode_q <= wr_data[0];
  end

  cal_prescaler #(.PRESCALE_DIV(PRESCALE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .clear(wr_en), .step(step)
  );

  cal_time_chain u_time (
    .clk(clk), .rst_n(rst_n), .step(step), .mode12(mode_q),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data[8:0]),
    .hund(hund_o), .sec(sec_o), .min(min_o), .hour24(hour24),
    .hund_wrap(hund_wrap), .sec_wrap(sec_wrap), .min_wrap(min_wrap),
    .day_step(day_step)
  );

  cal_date_chain u_date (
    .clk(clk), .rst_n(rst_n), .day_step(day_step),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .dom(dom_o), .mon(mon_o), .year(year_o), .dow(dow_o), .doy(doy_o),
    .leap(leap), .new_year(new_year)
  );

  assign mode12_o = mode_q;
  assign pm_o     = (hour24 >= 8'h12);
  assign hour_o   = mode_q ? hour_to_12(hour24) : hour24;
endmodule

// File: rtl/cal_checker.sv
module cal_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_en,
  input logic        wr_en,
  input logic [3:0]  wr_sel,
  input logic [7:0]  wr_low,
  input logic        step,
  input logic        hund_wrap,
  input logic        min_wrap,
  input logic        day_step,
  input logic        new_year,
  input logic        leap,
  input logic        mode12_o,
  input logic        pm_o,
  input logic [7:0]  hund_o,
  input logic [7:0]  sec_o,
  input logic [7:0]  hour_o,
  input logic [7:0]  dom_o,
  input logic [7:0]  mon_o,
  input logic [3:0]  dow_o,
  input logic [11:0] doy_o
);
  assert_step_needs_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (tick_en && !wr_en));

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !wr_en) |=> ($stable(hund_o) && $stable(sec_o) && $stable(dom_o) && $stable(doy_o)));

  assert_hund_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hund_wrap |=> (hund_o == 8'h00 && sec_o != $past(sec_o)));

  assert_day_wrap_hour_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (day_step && !mode12_o) |=> (hour_o == 8'h00));

  assert_hour12_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode12_o |-> (hour_o != 8'h00 && hour_o <= 8'h12));

  assert_pm_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (min_wrap && mode12_o && hour_o == 8'h11 && !pm_o) |=> (pm_o && hour_o == 8'h12));

  assert_leap_feb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (day_step && leap && mon_o == 8'h02 && dom_o == 8'h28) |=> (dom_o == 8'h29));

  assert_dow_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (day_step && dow_o == 4'd7) |=> (dow_o == 4'd1));

  assert_doy_new_year_R10: assert property (@(posedge clk) disable iff (!rst_n)
    new_year |=> (doy_o == 12'h001 && mon_o == 8'h01));

  assert_write_hund_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 4'd0) |=> (hund_o == $past(wr_low)));
endmodule

bind bcd_calendar cal_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_low(wr_data[7:0]), .step(step), .hund_wrap(hund_wrap), .min_wrap(min_wrap),
  .day_step(day_step), .new_year(new_year), .leap(leap), .mode12_o(mode12_o),
  .pm_o(pm_o), .hund_o(hund_o), .sec_o(sec_o), .hour_o(hour_o), .dom_o(dom_o),
  .mon_o(mon_o), .dow_o(dow_o), .doy_o(doy_o)
);

// File: tb/tb_bcd_calendar.sv
`timescale 1ns/1ps
module tb_bcd_calendar;
  localparam int DIV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [11:0] wr_data = '0;
  logic [7:0]  hund_o, sec_o, min_o, hour_o, dom_o, mon_o, year_o;
  logic        pm_o, mode12_o;
  logic [3:0]  dow_o;
  logic [11:0] doy_o;

  int vectors = 0, fails = 0;
  bit done = 0;

  // Reference state in plain binary.
  int m_pre, m_hund, m_sec, m_min, m_hour, m_dom, m_mon, m_year, m_dow, m_doy, m_mode;

  always #2 clk = ~clk;

  bcd_calendar #(.PRESCALE_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .hund_o(hund_o), .sec_o(sec_o), .min_o(min_o),
    .hour_o(hour_o), .pm_o(pm_o), .mode12_o(mode12_o), .dom_o(dom_o),
    .mon_o(mon_o), .year_o(year_o), .dow_o(dow_o), .doy_o(doy_o)
  );

  function automatic int to_bcd(int v);
    return ((v / 100) << 8) | (((v / 10) % 10) << 4) | (v % 10);
  endfunction

  function automatic int from_bcd(int v);
    return ((v >> 8) & 15) * 100 + ((v >> 4) & 15) * 10 + (v & 15);
  endfunction

  function automatic int days_in(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic advance_day();
    bit ny;
    ny = (m_dom == days_in(m_mon, m_year)) && (m_mon == 12);
    m_dow = (m_dow % 7) + 1;
    if (ny || m_doy == ((m_year % 4 == 0) ? 366 : 365)) m_doy = 1; else m_doy++;
    if (m_dom == days_in(m_mon, m_year)) begin
      m_dom = 1;
      if (m_mon == 12) begin m_mon = 1; m_year = (m_year + 1) % 100; end
      else m_mon++;
    end else m_dom++;
  endtask

  task automatic advance_hund();
    m_hund++;
    if (m_hund < 100) return;
    m_hund = 0; m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0; m_hour++;
    if (m_hour < 24) return;
    m_hour = 0;
    advance_day();
  endtask

  task automatic model_write(int sel, int d);
    case (sel)
      0: m_hund = from_bcd(d & 255);
      1: m_sec  = from_bcd(d & 255);
      2: m_min  = from_bcd(d & 255);
      3: m_hour = m_mode ? (from_bcd(d & 255) % 12) + ((d >> 8) & 1) * 12 : from_bcd(d & 255);
      4: m_dom  = from_bcd(d & 255);
      5: m_mon  = from_bcd(d & 255);
      6: m_year = from_bcd(d & 255);
      7: m_dow  = d & 15;
      8: m_doy  = from_bcd(d);
      9: m_mode = d & 1;
      default: ;
    endcase
  endtask

  task automatic check(string tag, int got, int exp);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_all();
    int h12;
    h12 = (m_hour % 12 == 0) ? 12 : m_hour % 12;
    check("R2 R3 hundredths", hund_o, to_bcd(m_hund));
    check("R3 seconds", sec_o, to_bcd(m_sec));
    check("R3 minutes", min_o, to_bcd(m_min));
    check("R4 R5 R6 hour", hour_o, to_bcd(m_mode ? h12 : m_hour));
    check("R5 pm", pm_o, m_hour >= 12);
    check("R11 mode", mode12_o, m_mode);
    check("R7 R8 day of month", dom_o, to_bcd(m_dom));
    check("R7 month", mon_o, to_bcd(m_mon));
    check("R7 year", year_o, to_bcd(m_year));
    check("R9 day of week", dow_o, m_dow);
    check("R10 day of year", doy_o, to_bcd(m_doy));
  endtask

  // One clock: drive at the falling edge, predict, sample 1 ns after the rise.
  task automatic cyc(bit tk, bit wr, int sel, int d);
    @(negedge clk);
    tick_en = tk; wr_en = wr; wr_sel = 4'(sel); wr_data = 12'(d);
    if (wr) begin
      m_pre = 0;
      model_write(sel, d);
    end else if (tk) begin
      if (m_pre == DIV - 1) begin m_pre = 0; advance_hund(); end
      else m_pre++;
    end
    @(posedge clk);
    #1;
    check_all();
  endtask

  task automatic wr(int sel, int d);
    cyc(1'b0, 1'b1, sel, d);
  endtask

  task automatic set_eod(int yr, int mon, int dom);
    wr(6, to_bcd(yr)); wr(5, to_bcd(mon)); wr(4, to_bcd(dom));
    wr(0, 'h99); wr(1, 'h59); wr(2, 'h59);
    if (m_mode) wr(3, 'h111); else wr(3, 'h23);
  endtask

  task automatic rand_write();
    int sel, d;
    sel = $urandom % 10;
    case (sel)
      0: d = to_bcd($urandom % 100);
      1, 2: d = to_bcd($urandom % 60);
      3: d = m_mode ? (to_bcd(1 + $urandom % 12) | (($urandom % 2) << 8)) : to_bcd($urandom % 24);
      4: d = to_bcd(1 + $urandom % 28);
      5: d = to_bcd(1 + $urandom % 12);
      6: d = to_bcd($urandom % 100);
      7: d = 1 + $urandom % 7;
      8: d = to_bcd(1 + $urandom % 365);
      default: d = $urandom % 2;
    endcase
    wr(sel, d);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1357));
    m_pre = 0; m_hund = 0; m_sec = 0; m_min = 0; m_hour = 0;
    m_dom = 1; m_mon = 1; m_year = 0; m_dow = 1; m_doy = 1; m_mode = 0;
    repeat (3) @(negedge clk);
    #1;
    check_all();                          // R1 values while in reset
    @(negedge clk); rst_n = 1'b1;
    cyc(1'b0, 1'b0, 0, 0);                // R1 after release, R2 no tick
    cyc(1'b0, 1'b0, 0, 0);

    // R2: one hundredth per DIV enabled ticks; R11: write clears the prescaler
    cyc(1'b1, 1'b0, 0, 0);
    wr(0, 'h10);
    cyc(1'b1, 1'b0, 0, 0);
    cyc(1'b1, 1'b0, 0, 0);

    // R3 R4 R7 R9 R10: full wrap at end of year 99
    wr(7, 7); wr(8, 'h365);
    set_eod(99, 12, 31);
    cyc(1'b1, 1'b0, 0, 0); cyc(1'b1, 1'b0, 0, 0);

    // R8: leap and common February ends, including year 00
    set_eod(4, 2, 28);  cyc(1'b1, 1'b0, 0, 0); cyc(1'b1, 1'b0, 0, 0);
    set_eod(4, 2, 29);  cyc(1'b1, 1'b0, 0, 0); cyc(1'b1, 1'b0, 0, 0);
    set_eod(3, 2, 28);  cyc(1'b1, 1'b0, 0, 0); cyc(1'b1, 1'b0, 0, 0);
    set_eod(0, 2, 28);  cyc(1'b1, 1'b0, 0, 0); cyc(1'b1, 1'b0, 0, 0);

    // R5 R6: 12-hour view, AM to PM and PM to AM
    wr(9, 1);
    wr(0, 'h99); wr(1, 'h59); wr(2, 'h59); wr(3, 'h011);
    cyc(1'b1, 1'b0, 0, 0); cyc(1'b1, 1'b0, 0, 0);
    set_eod(21, 6, 30); cyc(1'b1, 1'b0, 0, 0); cyc(1'b1, 1'b0, 0, 0);
    wr(3, 'h112);
    wr(9, 0);                             // R5 mode change keeps time

    // Month ends from random dates, both views
    for (int i = 0; i < 150; i++) begin
      int yr, mo;
      yr = $urandom % 100; mo = 1 + $urandom % 12;
      if ($urandom % 3 == 0) wr(9, $urandom % 2);
      set_eod(yr, mo, days_in(mo, yr));
      cyc(1'b1, 1'b0, 0, 0); cyc(1'b1, 1'b0, 0, 0); cyc(1'b1, 1'b0, 0, 0);
    end

    // Random ticks with occasional random valid writes
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 40 == 0) rand_write();
      else cyc(($urandom % 4) != 0, 1'b0, 0, 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule